// File: doc/BRIEF.md
# Tamper Detection Controller

This block watches a set of tamper input pins (eight by default) and, per channel, reacts in the way software has chosen in a 32-bit control word. A channel can be switched off. It can watch for an edge and raise a wake request, or watch for an edge and also latch a timestamp. In the fourth mode it drives a pseudo-random reference level on a paired output pin and expects that level to come back on its input. When the reference does not come back, the channel trips and a timestamp is taken.

Every input first passes through a two-flop synchronizer. Edge-watching channels can send the synchronized level through a per-channel debounce state machine, and a per-channel bit selects the edge direction. A shared reference generator supplies a slow sample tick and the pseudo-random levels. Each channel's debouncer is a four-state machine:
- `DB_LOW`: the level is settled low. A tick that sees the input high moves it to `DB_RISING`.
- `DB_RISING`: a tick that sees the input low goes back to `DB_LOW`. The tick that completes `DEB_CNT` consecutive high samples moves it to `DB_HIGH`.
- `DB_HIGH` and `DB_FALLING` are the mirror images of the two states above.

The accepted level is high in `DB_HIGH` and `DB_FALLING`. When several channels trip in the same clock cycle, one timestamp is latched, together with the mask of those channels. Flags stay set until software writes 1 to them. The control word can only be changed while the global arm input is low.

Top module: `tamper_ctrl`

## Requirements
- R1: After reset, the control word, flags, wake, timestamp value, timestamp mask and reference outputs are all zero.
- R2: A control write is accepted when arm is low and ignored when arm is high. The control word layout is:
  - bits [2n+1:2n]: action of channel n (0 off, 1 wake, 2 stamp, 3 active-layer);
  - bit 16+n: edge polarity (1 rising, 0 falling);
  - bit 24+n: debounce enable.
- R3: A channel whose action is off never sets its flag, whatever happens on its input.
- R4: An edge-watching channel trips on the selected edge only. Polarity bit 1 means a rising edge and 0 means a falling edge; the opposite edge sets no flag.
- R5: With debounce enabled, a new input level is accepted only after `DEB_CNT` consecutive sample ticks agree, so shorter pulses are ignored. With debounce disabled, a pulse of a few clocks trips the channel.
- R6: A wake-action trip sets the channel flag and leaves the timestamp value and mask unchanged.
- R7: A stamp-action or active-layer trip latches `ts_time` into `ts_value` and records in `ts_mask` every channel that tripped in that cycle. Simultaneous trips latch once with a combined mask.
- R8: An active-layer channel drives a pseudo-random level on its output, and every other channel drives 0. While the input follows the output, no trip occurs. On each tick, an input that differs from the output sets the flag and takes a timestamp. The polarity and debounce bits have no effect in this mode.
- R9: Flags are sticky. Writing 1 to a bit of `flag_clr` clears that flag, and writing 0 leaves it unchanged.
- R10: `wake` is high exactly when some flag is set for a channel whose current action is not off.
- R11: While arm is low, no channel trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Global enable: detection on, control writes locked |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_q | output | 32 | Current control word |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | NUM_CH | Write-1-to-clear mask |
| ts_time | input | TS_W | Time value to latch on capture |
| tamp_in | input | NUM_CH | Tamper input pins |
| tamp_out | output | NUM_CH | Active-layer reference outputs |
| flags | output | NUM_CH | Sticky per-channel tamper flags |
| wake | output | 1 | Wake request |
| ts_value | output | TS_W | Latched timestamp |
| ts_mask | output | NUM_CH | Channels that tripped at the last capture |

## Verification
The bench builds the block with eight channels, a tick every 4 clocks and `DEB_CNT` = 3. With these values a fully debounced transition takes about a dozen clocks, so a 3-clock glitch lies well below the filter's reach, and a long hold lies well above it, within short test windows. A tick period of 4 is the smallest that keeps the looped-back reference aligned with the input sample. The bench therefore exercises that margin with matched and deliberately inverted loopback on one active-layer channel.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
    typedef enum logic [1:0] {
        ACT_OFF   = 2'd0,
        ACT_WAKE  = 2'd1,
        ACT_STAMP = 2'd2,
        ACT_MESH  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        DB_LOW,
        DB_RISING,
        DB_HIGH,
        DB_FALLING
    } db_state_e;

    localparam int CTL_W      = 32;
    localparam int POL_BASE   = 16;
    localparam int DEB_BASE   = 24;
endpackage

// File: rtl/tamper_refgen.sv
module tamper_refgen #(
    parameter int NUM_CH   = 8,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              tick,
    output logic [NUM_CH-1:0] ref_bits
);
    localparam int TDW    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int LFSR_W = 8;

    logic [TDW-1:0]    div_q;
    logic [LFSR_W-1:0] lfsr_q;

    assign tick = (div_q == TDW'(TICK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            lfsr_q <= 8'hA5;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick)
                lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ref
        assign ref_bits[n] = lfsr_q[n % LFSR_W];
    end
endmodule

// File: rtl/tamper_chan.sv
module tamper_chan
    import tamper_pkg::*;
#(
    parameter int DEB_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    input  act_e act,
    input  logic pol_rise,
    input  logic deb_en,
    input  logic ref_bit,
    output logic ref_out,
    output logic trip
);
    localparam int CNT_W = $clog2(DEB_CNT + 1);

    logic             s1_q, s2_q;
    db_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             deb_level, filt, prev_q;
    logic             rise, fall, edge_trip, mesh_trip;

    // synchronizer, edge history and reference output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
            prev_q  <= 1'b0;
            ref_out <= 1'b0;
        end else begin
            s1_q    <= pin;
            s2_q    <= s1_q;
            prev_q  <= filt;
            ref_out <= (act == ACT_MESH) ? ref_bit : 1'b0;
        end
    end

    // debounce state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // debounce next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick) begin
            unique case (state_q)
                DB_LOW: if (s2_q) begin
                    if (DEB_CNT <= 1) state_d = DB_HIGH;
                    else begin state_d = DB_RISING; cnt_d = CNT_W'(1); end
                end
                DB_RISING: begin
                    if (!s2_q) state_d = DB_LOW;
                    else if (cnt_q == CNT_W'(DEB_CNT - 1)) state_d = DB_HIGH;
                    else cnt_d = cnt_q + 1'b1;
                end
                DB_HIGH: if (!s2_q) begin
                    if (DEB_CNT <= 1) state_d = DB_LOW;
                    else begin state_d = DB_FALLING; cnt_d = CNT_W'(1); end
                end
                DB_FALLING: begin
                    if (s2_q) state_d = DB_HIGH;
                    else if (cnt_q == CNT_W'(DEB_CNT - 1)) state_d = DB_LOW;
                    else cnt_d = cnt_q + 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        deb_level = (state_q == DB_HIGH) || (state_q == DB_FALLING);
        filt      = deb_en ? deb_level : s2_q;
        rise      = filt & ~prev_q;
        fall      = ~filt & prev_q;
        edge_trip = ((act == ACT_WAKE) || (act == ACT_STAMP)) && (pol_rise ? rise : fall);
        mesh_trip = (act == ACT_MESH) && tick && (s2_q != ref_out);
        trip      = edge_trip | mesh_trip;
    end

    assert_deb_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(deb_level));
    assert_ref_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act != ACT_MESH) |=> (ref_out == 1'b0));
endmodule

// File: rtl/tamper_ctrl.sv
module tamper_ctrl
    import tamper_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int DEB_CNT  = 4,
    parameter int TICK_DIV = 4,
    parameter int TS_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    input  logic              flag_clr_we,
    input  logic [NUM_CH-1:0] flag_clr,
    input  logic [TS_W-1:0]   ts_time,
    input  logic [NUM_CH-1:0] tamp_in,
    output logic [NUM_CH-1:0] tamp_out,
    output logic [NUM_CH-1:0] flags,
    output logic              wake,
    output logic [TS_W-1:0]   ts_value,
    output logic [NUM_CH-1:0] ts_mask
);
    logic              tick;
    logic [NUM_CH-1:0] ref_bits, raw_trip, trip, stamp_cls, live;
    logic [NUM_CH-1:0] clr_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else if (ctl_we && !arm) ctl_q <= ctl_wdata;
    end

    tamper_refgen #(.NUM_CH(NUM_CH), .TICK_DIV(TICK_DIV)) u_ref (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ref_bits(ref_bits)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        act_e act_n;
        assign act_n        = act_e'(ctl_q[2*n +: 2]);
        assign stamp_cls[n] = (act_n == ACT_STAMP) || (act_n == ACT_MESH);
        assign live[n]      = (act_n != ACT_OFF);

        tamper_chan #(.DEB_CNT(DEB_CNT)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .pin(tamp_in[n]),
            .act(act_n), .pol_rise(ctl_q[POL_BASE + n]), .deb_en(ctl_q[DEB_BASE + n]),
            .ref_bit(ref_bits[n]), .ref_out(tamp_out[n]), .trip(raw_trip[n])
        );
    end

    assign trip    = arm ? raw_trip : '0;
    assign clr_eff = flag_clr_we ? flag_clr : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags    <= '0;
            ts_value <= '0;
            ts_mask  <= '0;
        end else begin
            flags <= (flags & ~clr_eff) | trip;
            if (|(trip & stamp_cls)) begin
                ts_value <= ts_time;
                ts_mask  <= trip;
            end
        end
    end

    assign wake = |(flags & live);

    assert_ctl_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> $stable(ctl_q));
    assert_no_trip_disarmed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> ((flags & ~$past(flags)) == '0));
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~(flag_clr_we ? flag_clr : '0)))
                  == $past(flags & ~(flag_clr_we ? flag_clr : '0))));
endmodule

// File: tb/test_tamper_ctrl.sv
`timescale 1ns/1ps
module test_tamper_ctrl;
    localparam int NCH = 8;
    localparam logic [7:0] AL = 8'h20;

    logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, ctl_we = 1'b0, flag_clr_we = 1'b0;
    logic [31:0] ctl_wdata = '0, ctl_q, ts_time = '0, ts_value;
    logic [NCH-1:0] flag_clr = '0, tamp_in, tamp_out, flags, ts_mask;
    logic [NCH-1:0] pin_drv = 8'h02;
    logic brk = 1'b0;
    logic wake;

    always #2.5 clk = ~clk;
    assign tamp_in = (pin_drv & ~AL) | ((tamp_out ^ {NCH{brk}}) & AL);

    tamper_ctrl #(.NUM_CH(NCH), .DEB_CNT(3), .TICK_DIV(4), .TS_W(32)) i_tamper_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .flag_clr_we(flag_clr_we), .flag_clr(flag_clr), .ts_time(ts_time),
        .tamp_in(tamp_in), .tamp_out(tamp_out), .flags(flags), .wake(wake),
        .ts_value(ts_value), .ts_mask(ts_mask)
    );

    typedef struct { string req; int sel; logic [31:0] exp; logic [31:0] got; } item_t;
    item_t q[$];
    event  chk_ev;
    int    n_chk = 0, n_bad = 0;
    bit    done = 1'b0;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_v(input string req, input int sel, input logic [31:0] exp,
                            input logic [31:0] got = '0);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp; it.got = got;
        q.push_back(it);
        -> chk_ev;
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = ctl_q;
                    1: act = {24'd0, flags};
                    2: act = {31'd0, wake};
                    3: act = ts_value;
                    4: act = {24'd0, ts_mask};
                    5: act = {24'd0, tamp_out};
                    default: act = it.got;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic wr_ctl(input logic [31:0] v);
        ctl_wdata = v; ctl_we = 1'b1; cyc(1); ctl_we = 1'b0;
    endtask

    task automatic clr(input logic [7:0] m);
        flag_clr = m; flag_clr_we = 1'b1; cyc(1); flag_clr_we = 1'b0;
    endtask

    localparam logic [31:0] CTL = 32'h3039_0D89;

    initial begin
        int seen0, seen1;
        cyc(3);
        // R1 reset state
        expect_v("R1", 0, 32'h0); expect_v("R1", 1, 0); expect_v("R1", 2, 0);
        expect_v("R1", 3, 0); expect_v("R1", 4, 0); expect_v("R1", 5, 0);
        rst_n = 1'b1; cyc(2);
        expect_v("R1", 1, 0);
        wr_ctl(CTL);
        expect_v("R2", 0, CTL);
        cyc(20);
        arm = 1'b1; cyc(20);
        expect_v("R8", 1, 0);                 // matched loopback: no trip
        wr_ctl(32'hFFFF_FFFF);
        expect_v("R2", 0, CTL);               // locked while armed
        // R8 reference outputs
        seen0 = 0; seen1 = 0;
        for (int i = 0; i < 64; i++) begin
            cyc(1);
            if (tamp_out[5]) seen1 = 1; else seen0 = 1;
        end
        expect_v("R8", 6, 1, (seen0 == 1 && seen1 == 1) ? 1 : 0);
        expect_v("R8", 6, 0, {24'd0, tamp_out & ~AL});
        // R3 off channel
        pin_drv[2] = 1'b1; cyc(10); pin_drv[2] = 1'b0; cyc(10);
        expect_v("R3", 1, 0);
        // R6 / R10 wake trip on ch0 rising
        pin_drv[0] = 1'b1; cyc(10);
        expect_v("R6", 1, 32'h01); expect_v("R10", 2, 1);
        expect_v("R6", 3, 0); expect_v("R6", 4, 0);
        clr(8'h01); cyc(1);
        expect_v("R9", 1, 0); expect_v("R10", 2, 0);
        // R4 opposite edge ignored
        pin_drv[0] = 1'b0; cyc(10);
        expect_v("R4", 1, 0);
        // R7 simultaneous stamp trips: ch1 falling, ch3 rising
        ts_time = 32'hCAFE_0001;
        pin_drv[1] = 1'b0; pin_drv[3] = 1'b1; cyc(10);
        expect_v("R7", 1, 32'h0A); expect_v("R7", 3, 32'hCAFE_0001); expect_v("R7", 4, 32'h0A);
        ts_time = 32'h0000_0BAD;
        // R5 debounced ch4: short glitch ignored, long hold accepted
        pin_drv[4] = 1'b1; cyc(3); pin_drv[4] = 1'b0; cyc(30);
        expect_v("R5", 1, 32'h0A);
        pin_drv[4] = 1'b1; cyc(40);
        expect_v("R5", 1, 32'h1A);
        expect_v("R6", 3, 32'hCAFE_0001);
        // R5 undebounced ch0 glitch passes
        pin_drv[0] = 1'b1; cyc(3); pin_drv[0] = 1'b0; cyc(10);
        expect_v("R5", 1, 32'h1B);
        // R9 clear semantics
        clr(8'h00); cyc(1); expect_v("R9", 1, 32'h1B);
        clr(8'h02); cyc(1); expect_v("R9", 1, 32'h19);
        clr(8'hFF); cyc(1); expect_v("R9", 1, 0);
        // R8 broken loopback trips ch5 with timestamp
        ts_time = 32'h0000_1234; brk = 1'b1; cyc(30);
        expect_v("R8", 1, 32'h20); expect_v("R8", 4, 32'h20); expect_v("R8", 3, 32'h1234);
        brk = 1'b0; cyc(10); clr(8'hFF); cyc(30);
        expect_v("R8", 1, 0);
        // R11 disarmed: nothing trips
        arm = 1'b0; cyc(2);
        brk = 1'b1; pin_drv[3] = 1'b0; cyc(10); pin_drv[3] = 1'b1; cyc(30);
        expect_v("R11", 1, 0);
        brk = 1'b0; cyc(10);
        // R10 wake follows current action
        arm = 1'b1; cyc(4);
        pin_drv[0] = 1'b1; cyc(10);
        expect_v("R10", 1, 32'h01); expect_v("R10", 2, 1);
        arm = 1'b0; cyc(2);
        wr_ctl(CTL & ~32'h3);
        expect_v("R2", 0, CTL & ~32'h3);
        expect_v("R10", 2, 0); expect_v("R10", 1, 32'h01);
        cyc(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule